// File: doc/BRIEF.md
# Synchronous Burst Read Latency Controller

This block is the host side of a read path to a 16-bit parallel NOR-style flash. A small configuration register holds a timing-mode bit and a 3-bit latency code. A read request carries a start address and a burst-length code. The controller enables the memory, presents the address with a one-clock active-low address-valid strobe, and waits for the first word. It then captures the requested number of words, one by one, and hands each one to the host on a registered valid/data pair. The address advances by one after every captured word.

There are two timing modes. In clocked burst mode the wait before the first word is set by the latency code, and the following words arrive on back-to-back clocks. In unclocked page mode every word is taken after a fixed, parameterised number of cycles, and the latency code plays no part. Latency codes 0 and 1 are reserved. A write that carries one of them is dropped and the old setting stays. A configuration write that arrives during a read is parked and takes effect once the controller is idle again.

Top module: `nbr_read_ctrl`

## Requirements
- R1: After reset the mode bit reads 1 (page mode), the latency code reads 4, chip enable and address strobe are high (inactive), and data-valid is low.
- R2: A configuration write with a latency code of 2 to 7, made while idle, updates the readback outputs at the next clock edge. A read that starts on that same edge still uses the previous setting.
- R3: A configuration write whose latency code is 0 or 1 is rejected, and both the mode bit and the latency code keep their previous values.
- R4: A configuration write made while a read is in progress does not change the readback or the read in flight. It takes effect one edge after the controller returns to idle, and rd_busy stays high until then.
- R5: An accepted request (rd_req high while rd_busy is low) is sampled at edge E0. In the following cycle chip enable goes low, the address strobe is low for exactly that one cycle, and mem_addr equals rd_addr.
- R6: In burst mode (mode bit 0) with latency code L, word k (k = 0, 1, ...) is sampled from mem_dq at edge E0+1+L+k. rdata_vld is high, with that word on rdata, in the cycle after that edge.
- R7: In page mode (mode bit 1), word k is sampled at edge E0+1+PAGE_WAIT*(k+1), whatever the latency code is.
- R8: Length code 0 requests 4 words, code 1 requests 8, and codes 2 and 3 request 16. rdata_vld is high in exactly that many cycles, and chip enable goes high right after the last word is sampled.
- R9: mem_addr holds rd_addr+k on the cycle before word k is sampled.
- R10: rd_busy is high for the whole read, and a request made while rd_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_page | input | 1 | Mode bit to write: 1 page, 0 burst |
| cfg_lat | input | 3 | Latency code to write |
| cfg_page_o | output | 1 | Current mode bit |
| cfg_lat_o | output | 3 | Current latency code |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read start address |
| rd_len | input | 2 | Burst length code |
| rd_busy | output | 1 | Read in progress or configuration pending |
| mem_addr | output | AW | Address to memory |
| mem_adv_n | output | 1 | Active-low address-valid strobe |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_dq | input | 16 | Data from memory |
| rdata_vld | output | 1 | Captured word valid |
| rdata | output | 16 | Captured word |

## Verification
If the wait counter is loaded wrongly, or the mode is latched wrongly, the controller samples mem_dq one or more cycles away from the window in which the bench memory drives real data. The word it picks up is then a marked filler value, so the fault shows on rdata on the very first word of the read. A wrong remaining-word count shows as an extra or a missing valid cycle, and as chip enable rising at the wrong edge. A wrong configuration state shows on the readback outputs, either on the cycle after the write or on the cycle after the pending write is applied. It also shows in the timing of the next read.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int DQ_W = 16;

    typedef logic [2:0] lat_t;
    localparam lat_t LAT_RST = 3'd4;
    localparam lat_t LAT_MIN = 3'd2;

    typedef struct packed {
        logic page;
        lat_t lat;
    } cfg_t;

    typedef enum logic [1:0] {S_IDLE, S_ADV, S_XFER} seq_st_e;

    // length code: 0 -> 4 words, 1 -> 8 words, otherwise 16 words
    function automatic logic [4:0] words_of(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd4;
            2'd1:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic lat_ok(input lat_t l);
        return l >= LAT_MIN;
    endfunction
endpackage

// File: rtl/nbr_cfg.sv
module nbr_cfg
    import nbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  cfg_t wr_cfg,
    input  logic idle,
    output cfg_t cur,
    output logic pend
);
    cfg_t cur_q, pend_cfg;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '{page: 1'b1, lat: LAT_RST};
            pend_cfg <= '0;
            pend_q   <= 1'b0;
        end else if (wr && !idle) begin
            pend_q   <= 1'b1;
            pend_cfg <= wr_cfg;
        end else if (idle) begin
            if (wr) begin
                if (lat_ok(wr_cfg.lat)) cur_q <= wr_cfg;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                if (lat_ok(pend_cfg.lat)) cur_q <= pend_cfg;
                pend_q <= 1'b0;
            end
        end
    end

    assign cur  = cur_q;
    assign pend = pend_q;

    // R3: a reserved code written while idle leaves the setting alone
    p_rej_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && idle && !lat_ok(wr_cfg.lat)) |=> $stable(cur_q));
    // R4: nothing changes the setting while a read runs
    p_hold_busy_r4: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(cur_q));
endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
    import nbr_pkg::*;
#(
    parameter int PAGE_WAIT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cfg_t       cfg,
    input  logic [1:0] len,
    output logic       capture,
    output logic       idle,
    output logic       adv_n,
    output logic       ce_n
);
    localparam int CW = $clog2((PAGE_WAIT > 7 ? PAGE_WAIT : 7) + 1);
    localparam logic [CW-1:0] PW_M1 = CW'(PAGE_WAIT - 1);

    seq_st_e        st;
    logic [CW-1:0]  cnt;
    logic [4:0]     left;
    logic           page_q;
    lat_t           lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            left   <= '0;
            page_q <= 1'b1;
            lat_q  <= LAT_RST;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st     <= S_ADV;
                    left   <= words_of(len);
                    page_q <= cfg.page;
                    lat_q  <= cfg.lat;
                end
                S_ADV: begin
                    st  <= S_XFER;
                    cnt <= page_q ? PW_M1 : CW'(lat_q) - CW'(1);
                end
                S_XFER: begin
                    if (cnt == '0) begin
                        left <= left - 5'd1;
                        cnt  <= page_q ? PW_M1 : '0;
                        if (left == 5'd1) st <= S_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign capture = (st == S_XFER) && (cnt == '0);
    assign idle    = (st == S_IDLE);
    assign adv_n   = (st != S_ADV);
    assign ce_n    = (st == S_IDLE);

    // R5: the strobe lasts one cycle and only with the chip enabled
    p_adv_single_r5: assert property (@(posedge clk) disable iff (rst)
        !adv_n |=> adv_n);
    p_adv_ce_r5: assert property (@(posedge clk) disable iff (rst)
        !adv_n |-> !ce_n);
    // R8: a word is taken only while the chip is enabled
    p_cap_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        capture |-> !ce_n);
endmodule

// File: rtl/nbr_addr.sv
module nbr_addr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= base;
        else if (inc)  addr <= addr + AW'(1);
    end

    // R9: one step per captured word
    p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> addr == $past(addr) + AW'(1));
endmodule

// File: rtl/nbr_read_ctrl.sv
module nbr_read_ctrl
    import nbr_pkg::*;
#(
    parameter int AW        = 20,
    parameter int PAGE_WAIT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic            cfg_page,
    input  logic [2:0]      cfg_lat,
    output logic            cfg_page_o,
    output logic [2:0]      cfg_lat_o,
    input  logic            rd_req,
    input  logic [AW-1:0]   rd_addr,
    input  logic [1:0]      rd_len,
    output logic            rd_busy,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_adv_n,
    output logic            mem_ce_n,
    input  logic [DQ_W-1:0] mem_dq,
    output logic            rdata_vld,
    output logic [DQ_W-1:0] rdata
);
    cfg_t cur, wr_cfg;
    logic idle, pend, start, capture;

    assign wr_cfg = '{page: cfg_page, lat: cfg_lat};
    assign start  = rd_req && idle && !pend;

    nbr_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wr_cfg(wr_cfg),
        .idle(idle), .cur(cur), .pend(pend)
    );

    nbr_seq #(.PAGE_WAIT(PAGE_WAIT)) u_seq (
        .clk(clk), .rst(rst), .start(start), .cfg(cur), .len(rd_len),
        .capture(capture), .idle(idle), .adv_n(mem_adv_n), .ce_n(mem_ce_n)
    );

    nbr_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .load(start), .base(rd_addr),
        .inc(capture), .addr(mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_vld <= 1'b0;
            rdata     <= '0;
        end else begin
            rdata_vld <= capture;
            if (capture) rdata <= mem_dq;
        end
    end

    assign cfg_page_o = cur.page;
    assign cfg_lat_o  = cur.lat;
    assign rd_busy    = !idle || pend;

    // R6: valid follows every capture
    p_vld_after_cap_r6: assert property (@(posedge clk) disable iff (rst)
        capture |=> rdata_vld);
    // R10: no new strobe while already busy
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |=> (mem_adv_n || $past(mem_adv_n)));
endmodule

// File: tb/nbr_read_ctrl_test.sv
module nbr_read_ctrl_test;
    localparam int AW = 20;
    localparam int PW = 3;

    logic clk = 0, rst = 1;
    logic cfg_wr = 0, cfg_page = 0;
    logic [2:0] cfg_lat = 0;
    logic cfg_page_o;
    logic [2:0] cfg_lat_o;
    logic rd_req = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [1:0] rd_len = 0;
    logic rd_busy;
    logic [AW-1:0] mem_addr;
    logic mem_adv_n, mem_ce_n;
    logic [15:0] mem_dq = 16'hE000;
    logic rdata_vld;
    logic [15:0] rdata;

    nbr_read_ctrl #(.AW(AW), .PAGE_WAIT(PW)) uut (.*);

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", what);
        end
    endtask

    // reference model state
    int exp_edge[$];
    logic [AW-1:0] exp_addr[$];
    logic [15:0] exp_dat[$];
    int ci = 0, di = 0;
    int e0 = -100, last = -100;
    logic [AW-1:0] cur_a = 0;
    string cur_tag = "R7";
    bit m_page = 1;
    int m_lat = 4;

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return {4'h3, a[11:0]};
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (ci < exp_edge.size() && exp_edge[ci] == cyc) begin
                chk(rdata_vld && rdata == exp_dat[ci],
                    $sformatf("%s word: vld=%0b data=%h expected vld=1 data=%h",
                              cur_tag, rdata_vld, rdata, exp_dat[ci]));
                ci++;
            end else begin
                chk(!rdata_vld, $sformatf("R8 extra valid at cycle %0d: vld=%0b expected 0",
                                          cyc, rdata_vld));
            end
            chk(mem_adv_n == (cyc != e0),
                $sformatf("R5 strobe at cycle %0d: %0b expected %0b", cyc, mem_adv_n, cyc != e0));
            chk(mem_ce_n == !(cyc >= e0 && cyc < last),
                $sformatf("R8 enable at cycle %0d: %0b expected %0b",
                          cyc, mem_ce_n, !(cyc >= e0 && cyc < last)));
            if (cyc == e0)
                chk(mem_addr == cur_a, $sformatf("R5 address: %h expected %h", mem_addr, cur_a));
            if (di < exp_edge.size() && exp_edge[di] == cyc + 1) begin
                chk(mem_addr == exp_addr[di],
                    $sformatf("R9 address before word: %h expected %h", mem_addr, exp_addr[di]));
                mem_dq = exp_dat[di];
                di++;
            end else begin
                mem_dq = 16'hE000 | 16'(cyc & 32'hFFF);
            end
        end
    end

    task automatic issue_read(input logic [AW-1:0] a, input logic [1:0] len);
        int n;
        n = (len == 0) ? 4 : (len == 1) ? 8 : 16;
        rd_req = 1; rd_addr = a; rd_len = len;
        e0 = cyc + 1;
        cur_a = a;
        cur_tag = m_page ? "R7" : "R6";
        for (int k = 0; k < n; k++) begin
            int e;
            e = m_page ? e0 + 1 + PW * (k + 1) : e0 + 1 + m_lat + k;
            exp_edge.push_back(e);
            exp_addr.push_back(a + AW'(k));
            exp_dat.push_back(mem_word(a + AW'(k)));
            last = e;
        end
        @(negedge clk);
        rd_req = 0;
    endtask

    task automatic wait_done();
        while (cyc < last) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] len);
        issue_read(a, len);
        wait_done();
    endtask

    task automatic cfg_write(input bit pg, input int lat, input string tag);
        cfg_wr = 1; cfg_page = pg; cfg_lat = 3'(lat);
        @(negedge clk);
        cfg_wr = 0;
        if (lat >= 2) begin m_page = pg; m_lat = lat; end
        chk(cfg_page_o == m_page && cfg_lat_o == 3'(m_lat),
            $sformatf("%s config: page=%0b lat=%0d expected page=%0b lat=%0d",
                      tag, cfg_page_o, cfg_lat_o, m_page, m_lat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cfg_page_o == 1 && cfg_lat_o == 4,
            $sformatf("R1 config: page=%0b lat=%0d expected 1/4", cfg_page_o, cfg_lat_o));
        chk(mem_ce_n && mem_adv_n && !rdata_vld && !rd_busy,
            $sformatf("R1 pins: ce=%0b adv=%0b vld=%0b busy=%0b expected 1/1/0/0",
                      mem_ce_n, mem_adv_n, rdata_vld, rd_busy));
        // R7 page mode, default setting
        do_read(20'h00100, 2'd0);
        cfg_write(1, 7, "R2");
        do_read(20'h00FFE, 2'd1);  // R7 latency code has no effect
        // R6 burst mode
        cfg_write(0, 4, "R2");
        do_read(20'h12340, 2'd1);
        // R3 reserved codes
        cfg_write(1, 0, "R3");
        cfg_write(1, 1, "R3");
        do_read(20'h00200, 2'd0);  // R3 still burst, lat 4
        cfg_write(0, 2, "R2");
        do_read(20'h0FFF8, 2'd2);  // R8 sixteen words
        cfg_write(0, 7, "R2");
        do_read(20'h00300, 2'd3);  // R8 code 3 also sixteen
        // R4 write while reading
        issue_read(20'h00400, 2'd1);
        repeat (2) @(negedge clk);
        cfg_wr = 1; cfg_page = 0; cfg_lat = 3'd5;
        @(negedge clk);
        cfg_wr = 0;
        chk(cfg_lat_o == 7, $sformatf("R4 held: lat=%0d expected 7", cfg_lat_o));
        wait_done();
        chk(cfg_lat_o == 7 && rd_busy,
            $sformatf("R4 at idle: lat=%0d busy=%0b expected 7/1", cfg_lat_o, rd_busy));
        @(negedge clk);
        m_lat = 5;
        chk(cfg_lat_o == 5 && !rd_busy,
            $sformatf("R4 applied: lat=%0d busy=%0b expected 5/0", cfg_lat_o, rd_busy));
        // R10 request while busy is ignored
        issue_read(20'h00500, 2'd0);
        @(negedge clk);
        chk(rd_busy, $sformatf("R10 busy: %0b expected 1", rd_busy));
        rd_req = 1; rd_addr = 20'h0ABC0; rd_len = 2'd2;
        @(negedge clk);
        rd_req = 0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(!rd_busy && mem_ce_n,
            $sformatf("R10 idle after: busy=%0b ce=%0b expected 0/1", rd_busy, mem_ce_n));
        // R2 write and read on the same edge: read keeps old setting
        cfg_wr = 1; cfg_page = 1; cfg_lat = 3'd3;
        issue_read(20'h00600, 2'd0);
        cfg_wr = 0;
        m_page = 1; m_lat = 3;
        chk(cfg_page_o == 1 && cfg_lat_o == 3,
            $sformatf("R2 same edge: page=%0b lat=%0d expected 1/3", cfg_page_o, cfg_lat_o));
        wait_done();
        do_read(20'h00700, 2'd0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule